// File: doc/BRIEF.md
# Display RAM access port

This block is the path a host uses to reach a display controller's data RAM. The RAM holds bytes organised as pages of columns. The block keeps a column address and a page address. A command loads either one. Every 8-bit data write or read then moves one of them forward by one. This lets the host stream consecutive bytes without loading the address again. An axis setting picks whether the column or the page moves. A separate mapping setting decides how the segment scan-out reads the RAM: column order may be normal or mirrored.

Host reads pass through a single latch stage. Each read returns the byte the latch already holds, and the latch is then refilled from RAM. As a result, the first read after any column or page load is a discarded dummy. That dummy read fetches the byte at the loaded address and leaves the address where it is. The following reads return bytes from the loaded address onward. In serial host mode, read strobes are ignored. The scan port is a combinational lookup indexed by page and segment.

Top module: `dram_port`

## Requirements
- R1: After reset the column and page are 0, the step axis is column, the mapping is normal, rd_data_o and rd_valid_o are 0, and a dummy read is pending. The first write lands at page 0, column 0.
- R2: An accepted write stores wr_data_i at the current page and column. With normal mapping, scan_data_o for (scan_page_i, scan_seg_i) shows the byte at that page and column.
- R3: With the column axis (axis flag 0), each accepted write or valid read moves the column up by one and wraps from NUM_COLS-1 to 0. The page stays unchanged.
- R4: With the page axis (axis flag 1), each accepted write or valid read moves the page up by one and wraps from NUM_PAGES-1 to 0. The column stays unchanged.
- R5: The first accepted read after reset or after a column or page load is a dummy read. rd_valid_o stays 0 and the address does not move. Each later read drives rd_data_o on the next cycle with the byte at the current address, pulses rd_valid_o for one cycle, and then steps the address.
- R6: While serial_mode_i is 1, rd_i has no effect: rd_valid_o stays 0, rd_data_o holds its value, and neither the address nor the pending dummy changes.
- R7: With the mirror flag set, scan segment s shows column NUM_COLS-1-s, and segments at NUM_COLS or above read 0. Host writes and reads keep using the logical column.
- R8: In a cycle where several inputs are asserted, cmd_valid_i wins over wr_i and wr_i wins over rd_i. The losing strobes are dropped.
- R9: The command opcodes on cmd_op_i are 1 (load column), 2 (load page), 3 (axis flag in cmd_arg_i[0]) and 4 (mirror flag in cmd_arg_i[0]). Any other opcode does nothing. A loaded column is cmd_arg_i modulo NUM_COLS, and a loaded page is cmd_arg_i modulo NUM_PAGES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| serial_mode_i | input | 1 | Serial host mode; blocks reads |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 3 | Command opcode |
| cmd_arg_i | input | 8 | Command argument |
| wr_i | input | 1 | Data write strobe |
| wr_data_i | input | 8 | Write byte |
| rd_i | input | 1 | Data read strobe |
| rd_data_o | output | 8 | Read byte, registered |
| rd_valid_o | output | 1 | One-cycle pulse for a non-dummy read |
| scan_page_i | input | PW | Scan-out page |
| scan_seg_i | input | CW | Scan-out segment index |
| scan_data_o | output | 8 | Scan-out byte |

## Verification
On every cycle the assertions check the following:
- address stepping and wrap on the selected axis, with the other axis held;
- that a load arms the dummy and that a dummy read raises no valid;
- that rd_valid_o only follows a read that was accepted;
- that serial-mode reads leave data and address untouched.

The bench scenarios cover what no single-cycle property can see:
- the data values that come back through the latch;
- the mirrored scan mapping;
- strobe priority as seen in the RAM contents;
- modulo loads.

These are all checked against a bench-side model of the RAM.

// File: rtl/dram_pkg.sv
package dram_pkg;
  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_COL  = 3'd1,
    OP_PAGE = 3'd2,
    OP_AXIS = 3'd3,
    OP_MIR  = 3'd4
  } dram_op_e;
endpackage

// File: rtl/dram_addr.sv
module dram_addr #(
  parameter int NUM_COLS  = 20,
  parameter int NUM_PAGES = 4,
  parameter int CW        = 5,
  parameter int PW        = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_col_i,
  input  logic          ld_page_i,
  input  logic          set_axis_i,
  input  logic          set_mir_i,
  input  logic [7:0]    arg_i,
  input  logic          step_i,
  output logic [CW-1:0] col_o,
  output logic [PW-1:0] page_o,
  output logic [CW-1:0] col_step_o,
  output logic [PW-1:0] page_step_o,
  output logic          axis_page_o,
  output logic          mir_o
);
  localparam logic [CW-1:0] COL_LAST  = CW'(NUM_COLS - 1);
  localparam logic [PW-1:0] PAGE_LAST = PW'(NUM_PAGES - 1);

  logic [7:0] col_mod, page_mod;

  assign col_mod     = arg_i % 8'(NUM_COLS);
  assign page_mod    = arg_i % 8'(NUM_PAGES);
  assign col_step_o  = (col_o == COL_LAST) ? '0 : col_o + 1'b1;
  assign page_step_o = (page_o == PAGE_LAST) ? '0 : page_o + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_o       <= '0;
      page_o      <= '0;
      axis_page_o <= 1'b0;
      mir_o       <= 1'b0;
    end else begin
      if (ld_col_i)   col_o       <= col_mod[CW-1:0];
      if (ld_page_i)  page_o      <= page_mod[PW-1:0];
      if (set_axis_i) axis_page_o <= arg_i[0];
      if (set_mir_i)  mir_o       <= arg_i[0];
      if (step_i) begin
        if (axis_page_o) page_o <= page_step_o;
        else             col_o  <= col_step_o;
      end
    end
  end
endmodule

// File: rtl/dram_array.sv
module dram_array #(
  parameter int NUM_COLS  = 20,
  parameter int NUM_PAGES = 4,
  parameter int CW        = 5,
  parameter int PW        = 2
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [PW-1:0] w_page_i,
  input  logic [CW-1:0] w_col_i,
  input  logic [7:0]    w_data_i,
  input  logic [PW-1:0] h_page_i,
  input  logic [CW-1:0] h_col_i,
  output logic [7:0]    h_data_o,
  input  logic [PW-1:0] s_page_i,
  input  logic [CW-1:0] s_col_i,
  input  logic          s_ok_i,
  output logic [7:0]    s_data_o
);
  localparam int DEPTH = NUM_COLS * NUM_PAGES;
  localparam int AW    = $clog2(DEPTH);

  logic [7:0] mem [DEPTH];
  logic [AW-1:0] w_idx, h_idx, s_idx;

  assign w_idx = AW'(w_page_i) * AW'(NUM_COLS) + AW'(w_col_i);
  assign h_idx = AW'(h_page_i) * AW'(NUM_COLS) + AW'(h_col_i);
  assign s_idx = AW'(s_page_i) * AW'(NUM_COLS) + AW'(s_col_i);

  always_ff @(posedge clk_i) begin
    if (we_i) mem[w_idx] <= w_data_i;
  end

  assign h_data_o = mem[h_idx];
  assign s_data_o = s_ok_i ? mem[s_idx] : 8'h00;
endmodule

// File: rtl/dram_rdpipe.sv
module dram_rdpipe (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       arm_i,
  input  logic       rd_i,
  input  logic [7:0] word_i,
  output logic [7:0] data_o,
  output logic       valid_o,
  output logic       dummy_o
);
  logic [7:0] lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q   <= '0;
      data_o  <= '0;
      valid_o <= 1'b0;
      dummy_o <= 1'b1;
    end else begin
      valid_o <= 1'b0;
      if (arm_i) dummy_o <= 1'b1;
      if (rd_i) begin
        data_o  <= lat_q;
        valid_o <= ~dummy_o;
        lat_q   <= word_i;
        dummy_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dram_port.sv
module dram_port
  import dram_pkg::*;
#(
  parameter int NUM_COLS  = 20,
  parameter int NUM_PAGES = 4,
  parameter int CW        = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1,
  parameter int PW        = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          serial_mode_i,
  input  logic          cmd_valid_i,
  input  logic [2:0]    cmd_op_i,
  input  logic [7:0]    cmd_arg_i,
  input  logic          wr_i,
  input  logic [7:0]    wr_data_i,
  input  logic          rd_i,
  output logic [7:0]    rd_data_o,
  output logic          rd_valid_o,
  input  logic [PW-1:0] scan_page_i,
  input  logic [CW-1:0] scan_seg_i,
  output logic [7:0]    scan_data_o
);
  logic acc_wr, acc_rd, ld_col, ld_page, set_axis, set_mir;
  logic [CW-1:0] col_q, col_step, h_col, s_col;
  logic [PW-1:0] page_q, page_step, h_page;
  logic axis_q, mir_q, dummy_q, step, s_ok;
  logic [7:0] h_word;

  // priority: command > write > read
  assign acc_wr   = wr_i & ~cmd_valid_i;
  assign acc_rd   = rd_i & ~cmd_valid_i & ~wr_i & ~serial_mode_i;
  assign ld_col   = cmd_valid_i & (cmd_op_i == OP_COL);
  assign ld_page  = cmd_valid_i & (cmd_op_i == OP_PAGE);
  assign set_axis = cmd_valid_i & (cmd_op_i == OP_AXIS);
  assign set_mir  = cmd_valid_i & (cmd_op_i == OP_MIR);
  assign step     = acc_wr | (acc_rd & ~dummy_q);

  dram_addr #(.NUM_COLS(NUM_COLS), .NUM_PAGES(NUM_PAGES), .CW(CW), .PW(PW)) u_addr (
    .clk_i, .rst_ni,
    .ld_col_i(ld_col), .ld_page_i(ld_page), .set_axis_i(set_axis), .set_mir_i(set_mir),
    .arg_i(cmd_arg_i), .step_i(step),
    .col_o(col_q), .page_o(page_q), .col_step_o(col_step), .page_step_o(page_step),
    .axis_page_o(axis_q), .mir_o(mir_q)
  );

  // latch refill: dummy fetches current address, valid read fetches stepped one
  always_comb begin
    h_col  = col_q;
    h_page = page_q;
    if (!dummy_q) begin
      if (axis_q) h_page = page_step;
      else        h_col  = col_step;
    end
  end

  assign s_ok  = (scan_seg_i <= CW'(NUM_COLS - 1));
  assign s_col = mir_q ? CW'(NUM_COLS - 1) - scan_seg_i : scan_seg_i;

  dram_array #(.NUM_COLS(NUM_COLS), .NUM_PAGES(NUM_PAGES), .CW(CW), .PW(PW)) u_mem (
    .clk_i,
    .we_i(acc_wr), .w_page_i(page_q), .w_col_i(col_q), .w_data_i(wr_data_i),
    .h_page_i(h_page), .h_col_i(h_col), .h_data_o(h_word),
    .s_page_i(scan_page_i), .s_col_i(s_col), .s_ok_i(s_ok), .s_data_o(scan_data_o)
  );

  dram_rdpipe u_rd (
    .clk_i, .rst_ni,
    .arm_i(ld_col | ld_page), .rd_i(acc_rd), .word_i(h_word),
    .data_o(rd_data_o), .valid_o(rd_valid_o), .dummy_o(dummy_q)
  );
endmodule

// File: rtl/dram_port_chk.sv
module dram_port_chk #(
  parameter int NUM_COLS  = 20,
  parameter int NUM_PAGES = 4,
  parameter int CW        = 5,
  parameter int PW        = 2
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          serial_mode_i,
  input logic          cmd_valid_i,
  input logic [2:0]    cmd_op_i,
  input logic          wr_i,
  input logic          rd_i,
  input logic [7:0]    rd_data_o,
  input logic          rd_valid_o,
  input logic [CW-1:0] col_q,
  input logic [PW-1:0] page_q,
  input logic          axis_q,
  input logic          dummy_q
);
  logic c_wr, c_rd, c_ld;
  assign c_wr = wr_i && !cmd_valid_i;
  assign c_rd = rd_i && !cmd_valid_i && !wr_i && !serial_mode_i;
  assign c_ld = cmd_valid_i && (cmd_op_i == 3'd1 || cmd_op_i == 3'd2);

  a_r3_col_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_wr && !axis_q) |=> (col_q == (($past(col_q) == CW'(NUM_COLS - 1)) ? '0 : $past(col_q) + 1'b1)));
  a_r3_page_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_wr && !axis_q) |=> $stable(page_q));
  a_r4_page_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_wr && axis_q) |=> (page_q == (($past(page_q) == PW'(NUM_PAGES - 1)) ? '0 : $past(page_q) + 1'b1)));
  a_r4_col_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_wr && axis_q) |=> $stable(col_q));
  a_r5_load_arms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_ld |=> dummy_q);
  a_r5_dummy_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_rd && dummy_q) |=> (!rd_valid_o && $stable(col_q) && $stable(page_q)));
  a_r5_valid_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(c_rd && !dummy_q));
  a_r6_serial_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (serial_mode_i && rd_i && !cmd_valid_i && !wr_i) |=>
      (!rd_valid_o && $stable(rd_data_o) && $stable(col_q) && $stable(page_q) && $stable(dummy_q)));
endmodule

bind dram_port dram_port_chk #(.NUM_COLS(NUM_COLS), .NUM_PAGES(NUM_PAGES), .CW(CW), .PW(PW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .serial_mode_i(serial_mode_i),
  .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i), .wr_i(wr_i), .rd_i(rd_i),
  .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o),
  .col_q(col_q), .page_q(page_q), .axis_q(axis_q), .dummy_q(dummy_q)
);

// File: tb/dram_port_test.sv
`timescale 1ns/1ps
module dram_port_test;
  localparam int NC = 20;
  localparam int NP = 4;
  localparam int CW = 5;
  localparam int PW = 2;

  logic clk = 0, rst_ni = 0;
  logic serial_mode_i = 0, cmd_valid_i = 0, wr_i = 0, rd_i = 0;
  logic [2:0] cmd_op_i = 0;
  logic [7:0] cmd_arg_i = 0, wr_data_i = 0, rd_data_o, scan_data_o;
  logic rd_valid_o;
  logic [PW-1:0] scan_page_i = 0;
  logic [CW-1:0] scan_seg_i = 0;

  always #2.5 clk = ~clk;

  dram_port uut (.clk_i(clk), .rst_ni, .serial_mode_i, .cmd_valid_i, .cmd_op_i, .cmd_arg_i,
    .wr_i, .wr_data_i, .rd_i, .rd_data_o, .rd_valid_o, .scan_page_i, .scan_seg_i, .scan_data_o);

  int total = 0, bad = 0;
  int m_mem [NP][NC];
  int m_col, m_page, m_axis, m_mir, m_dummy, m_lat, e_data, e_valid;
  bit done = 0;

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic m_step();
    if (m_axis != 0) m_page = (m_page == NP - 1) ? 0 : m_page + 1;
    else             m_col  = (m_col == NC - 1) ? 0 : m_col + 1;
  endtask

  task automatic m_reset();
    m_col = 0; m_page = 0; m_axis = 0; m_mir = 0; m_dummy = 1; m_lat = 0; e_data = 0; e_valid = 0;
  endtask

  // one cycle: inputs set at negedge, outputs checked at following negedge
  task automatic cyc(string tag, bit cv, int op, int arg, bit w, int wd, bit r, bit ser);
    cmd_valid_i = cv; cmd_op_i = 3'(op); cmd_arg_i = 8'(arg);
    wr_i = w; wr_data_i = 8'(wd); rd_i = r; serial_mode_i = ser;
    @(posedge clk);
    e_valid = 0;
    if (cv) begin
      case (op)
        1: begin m_col = arg % NC; m_dummy = 1; end
        2: begin m_page = arg % NP; m_dummy = 1; end
        3: m_axis = arg & 1;
        4: m_mir = arg & 1;
        default: ;
      endcase
    end else if (w) begin
      m_mem[m_page][m_col] = wd & 8'hff;
      m_step();
    end else if (r && !ser) begin
      e_data = m_lat;
      e_valid = !m_dummy;
      if (m_dummy) m_dummy = 0;
      else m_step();
      m_lat = m_mem[m_page][m_col];
    end
    @(negedge clk);
    cmd_valid_i = 0; wr_i = 0; rd_i = 0;
    chk(tag, rd_valid_o, e_valid);
    chk(tag, rd_data_o, e_data);
  endtask

  task automatic scan_all(string tag);
    for (int p = 0; p < NP; p++)
      for (int s = 0; s < NC + 2; s++) begin
        scan_page_i = PW'(p); scan_seg_i = CW'(s);
        #0.5;
        if (s >= NC) chk(tag, scan_data_o, 0);
        else chk(tag, scan_data_o, m_mem[p][m_mir ? NC - 1 - s : s]);
      end
  endtask

  task automatic do_reset();
    rst_ni = 0; #7; rst_ni = 1; m_reset(); @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=1 exp=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int p = 0; p < NP; p++) for (int c = 0; c < NC; c++) m_mem[p][c] = 0;
    m_reset();
    @(negedge clk); #1; rst_ni = 1; @(negedge clk);
    chk("R1", rd_valid_o, 0);
    chk("R1", rd_data_o, 0);
    cyc("R1", 0, 0, 0, 1, 8'hA5, 0, 0);
    scan_page_i = 0; scan_seg_i = 0; #0.5;
    chk("R1", scan_data_o, 8'hA5);
    // fill array; column wraps back to 0 within each page
    for (int p = 0; p < NP; p++) begin
      cyc("R9", 1, 2, p, 0, 0, 0, 0);
      cyc("R9", 1, 1, 0, 0, 0, 0, 0);
      for (int c = 0; c < NC + 1; c++) cyc("R3", 0, 0, 0, 1, $urandom_range(0, 255), 0, 0);
    end
    scan_all("R2");
    // column wrap on read
    cyc("R3", 1, 2, 1, 0, 0, 0, 0);
    cyc("R3", 1, 1, NC - 2, 0, 0, 0, 0);
    cyc("R5", 0, 0, 0, 0, 0, 1, 0);
    for (int i = 0; i < 4; i++) cyc("R3", 0, 0, 0, 0, 0, 1, 0);
    // page axis wrap
    cyc("R4", 1, 3, 1, 0, 0, 0, 0);
    cyc("R4", 1, 2, NP - 1, 0, 0, 0, 0);
    cyc("R4", 1, 1, 3, 0, 0, 0, 0);
    cyc("R4", 0, 0, 0, 1, 8'h3C, 0, 0);
    cyc("R4", 0, 0, 0, 1, 8'hC3, 0, 0);
    cyc("R4", 0, 0, 0, 0, 0, 1, 0);
    cyc("R4", 0, 0, 0, 0, 0, 1, 0);
    scan_all("R4");
    // serial mode blocks reads
    cyc("R6", 1, 1, 7, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) cyc("R6", 0, 0, 0, 0, 0, 1, 1);
    cyc("R6", 0, 0, 0, 0, 0, 1, 0);
    cyc("R6", 0, 0, 0, 0, 0, 1, 1);
    cyc("R6", 0, 0, 0, 0, 0, 1, 0);
    // mirror mapping
    cyc("R7", 1, 4, 1, 0, 0, 0, 0);
    scan_all("R7");
    cyc("R7", 1, 3, 0, 0, 0, 0, 0);
    cyc("R7", 1, 1, 2, 0, 0, 0, 0);
    cyc("R7", 0, 0, 0, 1, 8'h77, 0, 0);
    scan_all("R7");
    // priority
    cyc("R8", 1, 1, 5, 1, 8'hEE, 1, 0);
    cyc("R8", 0, 0, 0, 1, 8'h11, 1, 0);
    cyc("R8", 1, 0, 0, 1, 8'h22, 0, 0);
    cyc("R8", 1, 6, 1, 0, 0, 0, 0);
    scan_all("R8");
    // modulo load
    cyc("R9", 1, 2, NP + 2, 0, 0, 0, 0);
    cyc("R9", 1, 1, NC + 3, 0, 0, 0, 0);
    cyc("R9", 0, 0, 0, 0, 0, 1, 0);
    cyc("R9", 0, 0, 0, 0, 0, 1, 0);
    // reset leaves dummy pending
    do_reset();
    chk("R1", rd_valid_o, 0);
    cyc("R1", 0, 0, 0, 0, 0, 1, 0);
    cyc("R1", 0, 0, 0, 0, 0, 1, 0);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      int k = $urandom_range(0, 19);
      bit ser = ($urandom_range(0, 9) == 0);
      if (k < 2)       cyc("R5", 1, $urandom_range(1, 2), $urandom_range(0, 255), 0, 0, 0, 0);
      else if (k < 3)  cyc("R5", 1, $urandom_range(0, 7), $urandom_range(0, 3), 0, 0, 0, 0);
      else if (k < 9)  cyc("R5", 0, 0, 0, 1, $urandom_range(0, 255), $urandom_range(0, 1), ser);
      else if (k < 18) cyc("R5", 0, 0, 0, 0, 0, 1, ser);
      else             cyc("R5", 0, 0, 0, 0, 0, 0, 0);
      if (i % 500 == 499) scan_all("R7");
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule